// File: doc/BRIEF.md
# Two-Port Adapter Interrupt Controller

This block is the register file and interrupt logic of a byte-wide peripheral adapter with two eight-bit ports, A and B. A host reaches sixteen byte registers through a 4-bit select, a write strobe and a read strobe. It holds the two port output registers and the two direction registers, and a control register that sets the mode of four control inputs: two for port A and two for port B. Behind these sit a seven-bit interrupt flag set, a seven-bit enable mask and one active-high interrupt request.

Each control input passes through a synchronizer. It raises its flag only on the transition that its mode selects. Two flags are not driven by the control lines: the timer pair and the shifter are separate blocks, and they report through one-cycle event strobes. The host clears flags by writing ones to the flag register. Flags also clear implicitly when the host touches a port register, depending on the line's mode. A quiet alias of port A lets software reach that port without disturbing any flag.

Top module: `pia_irq_ctrl`

## Requirements
- R1: After reset the output, direction, control, flag and enable registers are all zero and `irq` is low.
- R2: Reads decode the select as follows. Select 0 returns port B and select 1 returns port A. For both, each bit comes from the input pin where its direction bit is 0 and from the output register where it is 1. Select 2 returns the port B direction register and select 3 the port A direction register. Select 12 returns the control register. Selects 4 to 11 read as zero, and writes to them change nothing.
- R3: Writing select 13 clears every flag in bits 6:0 whose data bit is 1. Data bit 7 has no effect.
- R4: Writing select 14 with data bit 7 set ORs data bits 6:0 into the enable mask. With bit 7 clear, it removes those bits from the mask. Reading select 14 returns the mask with bit 7 as 0.
- R5: `irq`, and bit 7 of a select-13 read, are 1 exactly when some bit 6:0 is set in both the flags and the mask.
- R6: The control register holds the line modes. Bit 0 sets the mode of port A line 1 and bit 4 that of port B line 1; for these, 1 means rising edge and 0 means falling edge. Bits 3:1 set the mode of port A line 2 and bits 7:5 that of port B line 2. For the line-2 fields, mode 0 is falling, 1 is falling without auto-clear, 2 is rising and 3 is rising without auto-clear. Only the selected transition sets a flag. The flag bits are: A1 bit 1, A2 bit 0, B1 bit 4, B2 bit 3. A flag appears SYNC_STAGES+1 clock edges after the pin changes.
- R7: A read or write of select 1 clears flag bit 1. It also clears bit 0, but only when the A2 mode is 0 or 2. Select 0 does the same for bits 4 and 3, using the B2 mode.
- R8: Select 15 reads and writes port A exactly like select 1 but clears no flag.
- R9: With a line-2 mode of 4 to 7, edges on that line never set its flag, and port accesses never clear it.
- R10: `evt_in[2]`, `evt_in[1]` and `evt_in[0]` set flag bits 6, 5 and 2 on each clock edge at which they are high.
- R11: When a flag is set and cleared in the same cycle, it ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 4 | Register select |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current select |
| irq | output | 1 | Interrupt request, active high |
| pa_in | input | 8 | Port A input pins |
| pa_out | output | 8 | Port A output register |
| pa_dir | output | 8 | Port A direction, 1 = output |
| pb_in | input | 8 | Port B input pins |
| pb_out | output | 8 | Port B output register |
| pb_dir | output | 8 | Port B direction, 1 = output |
| a_ctl1 | input | 1 | Port A control line 1 |
| a_ctl2 | input | 1 | Port A control line 2 |
| b_ctl1 | input | 1 | Port B control line 1 |
| b_ctl2 | input | 1 | Port B control line 2 |
| evt_in | input | 3 | Event strobes for flag bits 6, 5, 2 |

## Verification
The bench builds the block with SYNC_STAGES set to 2 rather than the default 1, so the deeper generate branch of the synchronizer is elaborated. Each control-line wait then spans three edges, which shows that the flag latency follows the parameter. Random control-register writes reach every line-2 mode, including the four ignored ones. A fixed-cycle directed case lines up an event strobe with a flag-register clear, which reaches the set-over-clear priority.

// File: rtl/pia_pkg.sv
package pia_pkg;
  localparam int DATA_W   = 8;
  localparam int SEL_W    = 4;
  localparam int FLAG_W   = 7;
  localparam int N_LINES  = 4;

  localparam logic [SEL_W-1:0] SEL_PB      = 4'h0;
  localparam logic [SEL_W-1:0] SEL_PA      = 4'h1;
  localparam logic [SEL_W-1:0] SEL_DIRB    = 4'h2;
  localparam logic [SEL_W-1:0] SEL_DIRA    = 4'h3;
  localparam logic [SEL_W-1:0] SEL_MODE    = 4'hC;
  localparam logic [SEL_W-1:0] SEL_FLAGS   = 4'hD;
  localparam logic [SEL_W-1:0] SEL_ENABLE  = 4'hE;
  localparam logic [SEL_W-1:0] SEL_PA_QUIET = 4'hF;

  // flag bit positions
  localparam int FB_A2 = 0;
  localparam int FB_A1 = 1;
  localparam int FB_SH = 2;
  localparam int FB_B2 = 3;
  localparam int FB_B1 = 4;
  localparam int FB_T2 = 5;
  localparam int FB_T1 = 6;

  typedef logic [2:0] line_mode_t;

  // Normalised 3-bit mode per line: line index 0=A1, 1=A2, 2=B1, 3=B2.
  // Single-bit lines map to mode 2 (rising) or 0 (falling).
  function automatic line_mode_t line_mode(input logic [DATA_W-1:0] ctl, input logic [1:0] idx);
    case (idx)
      2'd0:    return ctl[0] ? 3'd2 : 3'd0;
      2'd1:    return ctl[3:1];
      2'd2:    return ctl[4] ? 3'd2 : 3'd0;
      default: return ctl[7:5];
    endcase
  endfunction

  function automatic logic line_fires(input line_mode_t md, input logic prev, input logic cur);
    return !md[2] && (prev != cur) && (cur == md[1]);
  endfunction

  function automatic logic line_autoclr(input line_mode_t md);
    return !md[2] && !md[0];
  endfunction

  function automatic logic [2:0] line_flag_pos(input logic [1:0] idx);
    case (idx)
      2'd0:    return 3'(FB_A1);
      2'd1:    return 3'(FB_A2);
      2'd2:    return 3'(FB_B1);
      default: return 3'(FB_B2);
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] port_view(input logic [DATA_W-1:0] pins,
                                                  input logic [DATA_W-1:0] outs,
                                                  input logic [DATA_W-1:0] dir);
    return (pins & ~dir) | (outs & dir);
  endfunction
endpackage

// File: rtl/pia_ctl_sync.sv
module pia_ctl_sync #(
  parameter int STAGES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic cur,
  output logic prev
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q[0] <= lvl;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], lvl};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= chain_q[STAGES-1];
  end

  assign cur = chain_q[STAGES-1];
endmodule

// File: rtl/pia_port_regs.sv
module pia_port_regs
  import pia_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              out_we,
  input  logic              dir_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] pins,
  output logic [DATA_W-1:0] out_q,
  output logic [DATA_W-1:0] dir_q,
  output logic [DATA_W-1:0] view
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= '0;
    end else begin
      if (out_we) out_q <= wdata;
      if (dir_we) dir_q <= wdata;
    end
  end

  assign view = port_view(pins, out_q, dir_q);
endmodule

// File: rtl/pia_flag_unit.sv
module pia_flag_unit
  import pia_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] flag_set,
  input  logic [FLAG_W-1:0] flag_clr,
  input  logic              en_wr,
  input  logic [DATA_W-1:0] en_wdata,
  output logic [FLAG_W-1:0] flag_q,
  output logic [FLAG_W-1:0] en_q,
  output logic              irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
    end else begin
      flag_q <= (flag_q & ~flag_clr) | flag_set;
      if (en_wr) begin
        if (en_wdata[DATA_W-1]) en_q <= en_q | en_wdata[FLAG_W-1:0];
        else                    en_q <= en_q & ~en_wdata[FLAG_W-1:0];
      end
    end
  end

  assign irq = |(flag_q & en_q);
endmodule

// File: rtl/pia_irq_ctrl.sv
module pia_irq_ctrl
  import pia_pkg::*;
#(
  parameter int SYNC_STAGES = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  input  logic [DATA_W-1:0] pa_in,
  output logic [DATA_W-1:0] pa_out,
  output logic [DATA_W-1:0] pa_dir,
  input  logic [DATA_W-1:0] pb_in,
  output logic [DATA_W-1:0] pb_out,
  output logic [DATA_W-1:0] pb_dir,
  input  logic              a_ctl1,
  input  logic              a_ctl2,
  input  logic              b_ctl1,
  input  logic              b_ctl2,
  input  logic [2:0]        evt_in
);
  logic [DATA_W-1:0]  mode_q;
  logic [DATA_W-1:0]  pa_view, pb_view;
  logic [N_LINES-1:0] line_lvl, line_cur, line_prev, line_hit;
  line_mode_t         line_md [N_LINES];
  logic [FLAG_W-1:0]  flag_set, flag_clr, flag_q, en_q;
  logic               acc_a, acc_b, flags_wr;

  assign line_lvl = {b_ctl2, b_ctl1, a_ctl2, a_ctl1};

  // per-line synchroniser and edge qualification
  generate
    for (genvar g = 0; g < N_LINES; g++) begin : g_line
      assign line_md[g] = line_mode(mode_q, 2'(g));
      pia_ctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (line_lvl[g]),
        .cur  (line_cur[g]),
        .prev (line_prev[g])
      );
      assign line_hit[g] = line_fires(line_md[g], line_prev[g], line_cur[g]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)                          mode_q <= '0;
    else if (bus_wr && bus_sel == SEL_MODE) mode_q <= bus_wdata;
  end

  assign acc_a    = (bus_wr || bus_rd) && (bus_sel == SEL_PA);
  assign acc_b    = (bus_wr || bus_rd) && (bus_sel == SEL_PB);
  assign flags_wr = bus_wr && (bus_sel == SEL_FLAGS);

  always_comb begin
    flag_set = '0;
    for (int i = 0; i < N_LINES; i++) begin
      if (line_hit[i]) flag_set[line_flag_pos(2'(i))] = 1'b1;
    end
    flag_set[FB_T1] = flag_set[FB_T1] | evt_in[2];
    flag_set[FB_T2] = flag_set[FB_T2] | evt_in[1];
    flag_set[FB_SH] = flag_set[FB_SH] | evt_in[0];
  end

  always_comb begin
    flag_clr = flags_wr ? bus_wdata[FLAG_W-1:0] : '0;
    if (acc_a) begin
      flag_clr[FB_A1] = 1'b1;
      if (line_autoclr(line_md[1])) flag_clr[FB_A2] = 1'b1;
    end
    if (acc_b) begin
      flag_clr[FB_B1] = 1'b1;
      if (line_autoclr(line_md[3])) flag_clr[FB_B2] = 1'b1;
    end
  end

  pia_port_regs u_port_a (
    .clk   (clk),
    .rst_n (rst_n),
    .out_we(bus_wr && (bus_sel == SEL_PA || bus_sel == SEL_PA_QUIET)),
    .dir_we(bus_wr && bus_sel == SEL_DIRA),
    .wdata (bus_wdata),
    .pins  (pa_in),
    .out_q (pa_out),
    .dir_q (pa_dir),
    .view  (pa_view)
  );

  pia_port_regs u_port_b (
    .clk   (clk),
    .rst_n (rst_n),
    .out_we(bus_wr && bus_sel == SEL_PB),
    .dir_we(bus_wr && bus_sel == SEL_DIRB),
    .wdata (bus_wdata),
    .pins  (pb_in),
    .out_q (pb_out),
    .dir_q (pb_dir),
    .view  (pb_view)
  );

  pia_flag_unit u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .flag_set(flag_set),
    .flag_clr(flag_clr),
    .en_wr   (bus_wr && bus_sel == SEL_ENABLE),
    .en_wdata(bus_wdata),
    .flag_q  (flag_q),
    .en_q    (en_q),
    .irq     (irq)
  );

  always_comb begin
    case (bus_sel)
      SEL_PB:                bus_rdata = pb_view;
      SEL_PA, SEL_PA_QUIET:  bus_rdata = pa_view;
      SEL_DIRB:              bus_rdata = pb_dir;
      SEL_DIRA:              bus_rdata = pa_dir;
      SEL_MODE:              bus_rdata = mode_q;
      SEL_FLAGS:             bus_rdata = {irq, flag_q};
      SEL_ENABLE:            bus_rdata = {1'b0, en_q};
      default:               bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pia_irq_chk.sv
module pia_irq_chk
  import pia_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [SEL_W-1:0]  bus_sel,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input logic [FLAG_W-1:0] flag_q,
  input logic [FLAG_W-1:0] en_q,
  input logic [FLAG_W-1:0] flag_set
);
  p_ifr_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel == SEL_FLAGS) |=>
      ((flag_q & $past(bus_wdata[FLAG_W-1:0]) & ~$past(flag_set)) == '0));

  p_ier_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel == SEL_ENABLE && bus_wdata[7]) |=>
      ((en_q & $past(bus_wdata[FLAG_W-1:0])) == $past(bus_wdata[FLAG_W-1:0])));

  p_ier_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel == SEL_ENABLE && !bus_wdata[7]) |=>
      ((en_q & $past(bus_wdata[FLAG_W-1:0])) == '0));

  p_irq_bit7_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel == SEL_FLAGS) |-> (bus_rdata[7] == irq));

  p_flag_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n) |=> ((flag_q & ~$past(flag_q) & ~$past(flag_set)) == '0));

  p_quiet_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_wr || bus_rd) && bus_sel == SEL_PA_QUIET) |=>
      (($past(flag_q[1:0]) & ~flag_q[1:0]) == 2'b00));

  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_set != '0) |=> ((flag_q & $past(flag_set)) == $past(flag_set)));
endmodule

bind pia_irq_ctrl pia_irq_chk u_pia_irq_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_sel  (bus_sel),
  .bus_wr   (bus_wr),
  .bus_rd   (bus_rd),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .irq      (irq),
  .flag_q   (flag_q),
  .en_q     (en_q),
  .flag_set (flag_set)
);

// File: tb/test_pia_irq_ctrl.sv
module test_pia_irq_ctrl;
  localparam int SYNC = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_sel = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       irq;
  logic [7:0] pa_in = '0, pa_out, pa_dir, pb_in = '0, pb_out, pb_dir;
  logic [3:0] lines = '0;
  logic [2:0] evt_in = '0;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench model
  logic [7:0] m_ora, m_orb, m_dira, m_dirb, m_mode;
  logic [6:0] m_flag, m_en;

  always #5 clk = ~clk;

  pia_irq_ctrl #(.SYNC_STAGES(SYNC)) i_pia_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .pa_in(pa_in), .pa_out(pa_out), .pa_dir(pa_dir),
    .pb_in(pb_in), .pb_out(pb_out), .pb_dir(pb_dir),
    .a_ctl1(lines[0]), .a_ctl2(lines[1]), .b_ctl1(lines[2]), .b_ctl2(lines[3]),
    .evt_in(evt_in)
  );

  function automatic logic m_irq();
    return (m_flag & m_en) != 7'd0;
  endfunction

  function automatic logic [7:0] merge(input logic [7:0] p, input logic [7:0] o, input logic [7:0] d);
    logic [7:0] r;
    for (int b = 0; b < 8; b++) r[b] = d[b] ? o[b] : p[b];
    return r;
  endfunction

  function automatic logic [7:0] m_read(input logic [3:0] a);
    case (a)
      4'h0: return merge(pb_in, m_orb, m_dirb);
      4'h1, 4'hF: return merge(pa_in, m_ora, m_dira);
      4'h2: return m_dirb;
      4'h3: return m_dira;
      4'hC: return m_mode;
      4'hD: return {m_irq(), m_flag};
      4'hE: return {1'b0, m_en};
      default: return 8'h00;
    endcase
  endfunction

  // 3-bit field of a line-2 mode; returns 1 if flag auto-clears on port access
  function automatic logic field_clears(input logic [2:0] f);
    return f == 3'd0 || f == 3'd2;
  endfunction

  task automatic m_port_touch(input logic [3:0] a);
    if (a == 4'h1) begin
      m_flag[1] = 1'b0;
      if (field_clears(m_mode[3:1])) m_flag[0] = 1'b0;
    end else if (a == 4'h0) begin
      m_flag[4] = 1'b0;
      if (field_clears(m_mode[7:5])) m_flag[3] = 1'b0;
    end
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_pins(input string req);
    chk({req, " irq"}, {7'd0, irq}, {7'd0, m_irq()});
    chk({req, " pa_out"}, pa_out, m_ora);
    chk({req, " pb_dir"}, pb_dir, m_dirb);
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    case (a)
      4'h0: begin m_orb = d; m_port_touch(a); end
      4'h1: begin m_ora = d; m_port_touch(a); end
      4'h2: m_dirb = d;
      4'h3: m_dira = d;
      4'hC: m_mode = d;
      4'hD: m_flag = m_flag & ~d[6:0];
      4'hE: m_en = d[7] ? (m_en | d[6:0]) : (m_en & ~d[6:0]);
      4'hF: m_ora = d;
      default: ;
    endcase
  endtask

  task automatic bus_read(input logic [3:0] a, input string req);
    @(negedge clk);
    bus_sel = a; bus_rd = 1'b1;
    #1;
    chk(req, bus_rdata, m_read(a));
    @(negedge clk);
    bus_rd = 1'b0;
    m_port_touch(a);
  endtask

  task automatic drive_line(input int i, input logic v);
    logic old;
    logic rising;
    logic live;
    logic [2:0] fld;
    old = lines[i];
    @(negedge clk);
    lines[i] = v;
    repeat (SYNC + 2) @(negedge clk);
    live = 1'b1;
    case (i)
      0: rising = m_mode[0];
      2: rising = m_mode[4];
      default: begin
        fld = (i == 1) ? m_mode[3:1] : m_mode[7:5];
        live = (fld < 3'd4);
        rising = (fld >= 3'd2);
      end
    endcase
    if (live && old != v && v == rising) begin
      case (i)
        0: m_flag[1] = 1'b1;
        1: m_flag[0] = 1'b1;
        2: m_flag[4] = 1'b1;
        default: m_flag[3] = 1'b1;
      endcase
    end
  endtask

  task automatic pulse_evt(input logic [2:0] e);
    @(negedge clk);
    evt_in = e;
    @(negedge clk);
    evt_in = 3'b000;
    if (e[2]) m_flag[6] = 1'b1;
    if (e[1]) m_flag[5] = 1'b1;
    if (e[0]) m_flag[2] = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    m_ora = 0; m_orb = 0; m_dira = 0; m_dirb = 0; m_mode = 0; m_flag = 0; m_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_pins("R1");
    pa_in = 8'hA5; pb_in = 8'h3C;
    bus_read(4'hD, "R1 flags");
    bus_read(4'hE, "R1 enable");
    bus_read(4'hC, "R1 mode");
    bus_read(4'h1, "R1 port A pins");

    // R2 direction merge and dead selects
    bus_write(4'h3, 8'hF0);
    bus_write(4'h1, 8'h5A);
    bus_read(4'h1, "R2 port A merge");
    bus_write(4'h2, 8'h0F);
    bus_write(4'h0, 8'hC3);
    bus_read(4'h0, "R2 port B merge");
    bus_write(4'h7, 8'hFF);
    bus_read(4'h7, "R2 dead select");
    chk_pins("R2");

    // R6 falling edge on A1 (mode 0), then R5 via enable, R4 set/clear
    drive_line(0, 1'b1);
    drive_line(0, 1'b0);
    bus_read(4'hD, "R6 A1 falling");
    chk_pins("R5 masked");
    bus_write(4'hE, 8'h82);
    chk_pins("R5 irq raised");
    bus_read(4'hE, "R4 set");
    bus_write(4'hE, 8'h02);
    bus_read(4'hE, "R4 clear");
    chk_pins("R5 irq dropped");
    bus_write(4'hE, 8'hFF);

    // R8 quiet alias keeps flags, R7 real access clears A1
    bus_read(4'hF, "R8 quiet read");
    bus_write(4'hF, 8'h11);
    bus_read(4'hD, "R8 flags kept");
    bus_read(4'h1, "R7 port A read");
    bus_read(4'hD, "R7 A1 cleared");

    // R7 no-autoclear mode 3 on A2, mode 2 on B2
    bus_write(4'hC, 8'b0100_0110);
    drive_line(1, 1'b1);
    drive_line(3, 1'b1);
    bus_read(4'hD, "R6 rising A2 B2");
    bus_write(4'h1, 8'h22);
    bus_write(4'h0, 8'h33);
    bus_read(4'hD, "R7 A2 kept, B2 cleared");

    // R9 ignored modes
    bus_write(4'hD, 8'h7F);
    bus_write(4'hC, 8'b1110_1010);
    drive_line(1, 1'b0);
    drive_line(1, 1'b1);
    drive_line(3, 1'b0);
    bus_read(4'hD, "R9 edges ignored");

    // R10 events, R3 flag clear, R11 set over clear
    pulse_evt(3'b111);
    bus_read(4'hD, "R10 events");
    bus_write(4'hD, 8'h84);
    bus_read(4'hD, "R3 clear bit2");
    @(negedge clk);
    bus_sel = 4'hD; bus_wdata = 8'h40; bus_wr = 1'b1; evt_in = 3'b100;
    @(negedge clk);
    bus_wr = 1'b0; evt_in = 3'b000;
    m_flag[6] = 1'b1;
    bus_read(4'hD, "R11 set wins");
    chk_pins("R11");

    // random mix
    for (int n = 0; n < 1500; n++) begin
      int op;
      op = int'($urandom % 10);
      pa_in = 8'($urandom); pb_in = 8'($urandom);
      if (op < 4)      bus_write(4'($urandom), 8'($urandom));
      else if (op < 7) bus_read(4'($urandom), "R2 R3 R4 R5 R7 random read");
      else if (op < 9) drive_line(int'($urandom % 4), 1'($urandom));
      else             pulse_evt(3'($urandom));
      chk_pins("R5 R6 R10 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule